// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns the data addresses issued by a small microcontroller core into a physical location: a region select and an index inside that region. The data space has 32 banks of 128 locations each. A direct access takes its bank from a bank-select register and its in-bank offset from the instruction. An indirect access takes a 16-bit pointer. The pointer can address the banks through a flat view of all 32 banks, or through a linear window. In the linear window the 80 general-purpose bytes of every bank follow one another in bank order with no gap.

The bank is changed with a single write to the bank-select register. The first twelve locations of every bank are core registers, and the working register is one of them. The last sixteen locations are common RAM. Both areas decode the same whatever bank is selected. Common RAM is not part of the linear window. The pointer can post-increment after an indirect access, so a loop can walk the whole linear window across bank borders. All decode is combinational from the current inputs and register state. The bank-select and pointer registers update on the clock edge.

Top module: `bank_addr_map`

## Requirements
- R1: The bank-select register resets to 0. A write (bsel_we_i high at an edge) loads bits [4:0] of bsel_wdata_i, and the new bank is visible on bank_sel_o and in direct decode from the cycle after the write.
- R2: Bits [7:5] of a bank-select write are ignored: writing 0xE3 selects bank 3.
- R3: Offsets 0x00–0x0B decode to region 0 (core register) with idx_o equal to the offset in every bank. The working register sits at offset 0x09.
- R4: Offsets 0x0C–0x1F decode to region 1 (peripheral register) with idx_o = bank×20 + (offset−0x0C).
- R5: Offsets 0x20–0x6F decode to region 2 (banked RAM) with idx_o = bank×80 + (offset−0x20), which is always below 2560.
- R6: Offsets 0x70–0x7F decode to region 3 (common RAM) with idx_o = offset−0x70 in every bank.
- R7: An indirect access with a pointer below 0x1000 decodes as bank = pointer[11:7] and offset = pointer[6:0]. Pointers 0x1000–0x1FFF decode as region 4 (unmapped).
- R8: Pointers 0x2000–0x29FF form the linear window. Region is 2, bank_o = (p−0x2000)/80, offset = 0x20 + (p−0x2000) mod 80, and idx_o = p−0x2000, so a linear access and a direct access to the same byte give the same index. Pointers 0x2A00 and above are unmapped.
- R9: The pointer resets to 0 and loads on ptr_we_i. When ind_i and post_inc_i are both high, it increments by one at the edge after the access and wraps from 0xFFFF to 0. A pointer load takes priority over the increment, and post_inc_i has no effect during a direct access.
- R10: An unmapped access drives idx_o = 0 and bank_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bsel_we_i | input | 1 | Bank-select write enable |
| bsel_wdata_i | input | 8 | Bank-select write data; bits [4:0] used |
| ptr_we_i | input | 1 | Pointer load enable |
| ptr_wdata_i | input | 16 | Pointer load value |
| ind_i | input | 1 | 1 = indirect access through pointer, 0 = direct |
| off_i | input | 7 | In-bank offset for a direct access |
| post_inc_i | input | 1 | Increment pointer after this indirect access |
| region_o | output | 3 | 0 core, 1 peripheral, 2 banked RAM, 3 common RAM, 4 unmapped |
| idx_o | output | 12 | Physical index inside the selected region |
| bank_o | output | 5 | Bank of the decoded access |
| bank_sel_o | output | 5 | Current bank-select value |
| ptr_o | output | 16 | Current pointer value |

## Verification
The assertions assume that reset is asserted from time zero and that all inputs are at known levels at every rising edge. The decode checks compare outputs and input ports in the same cycle, so they also assume the inputs stay stable between edges. The bench changes every input only on the falling edge and holds it until the next falling edge. It drives only the documented encodings. The pointer loads are chosen to land on each boundary: the flat-view and linear-window edges, the 80-byte crossings between banks, and the 16-bit wrap.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int OFF_W   = 7;
  localparam int BANK_SZ = 1 << OFF_W;
  localparam int CORE_N  = 12;
  localparam int GPR_LO  = 'h20;
  localparam int COM_LO  = 'h70;
  localparam int PER_N   = GPR_LO - CORE_N;
  localparam int COM_N   = BANK_SZ - COM_LO;

  typedef enum logic [2:0] {
    RG_CORE   = 3'd0,
    RG_PERIPH = 3'd1,
    RG_BANKED = 3'd2,
    RG_COMMON = 3'd3,
    RG_NONE   = 3'd4
  } region_e;
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
  parameter int BANK_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_q <= '0;
    else if (we_i) bank_q <= wdata_i[BANK_W-1:0];
  end

  assign bank_o = bank_q;

  AST_BSEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> bank_q == $past(wdata_i[BANK_W-1:0])); // R2
  AST_BSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bank_q)); // R1
endmodule

// File: rtl/ind_ptr.sv
module ind_ptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic             ind_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= '0;
    else if (we_i)           ptr_q <= wdata_i;
    else if (ind_i && inc_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_i && inc_i && !we_i) |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1))); // R9
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !(ind_i && inc_i)) |=> $stable(ptr_q)); // R9
  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ptr_q == $past(wdata_i)); // R9
endmodule

// File: rtl/addr_src.sv
// Selects bank/offset from direct fields or from the pointer (flat or linear view).
module addr_src
  import bank_map_pkg::*;
#(
  parameter int NUM_BANKS = 32,
  parameter int GPR_N     = 80,
  parameter int PTR_W     = 16,
  parameter int LIN_BASE  = 'h2000,
  parameter int BANK_W    = 5
) (
  input  logic             ind_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             hit_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0] off_o
);
  localparam int FLAT_SPAN = NUM_BANKS * BANK_SZ;
  localparam int LIN_SPAN  = NUM_BANKS * GPR_N;

  logic [PTR_W-1:0] lin, lin_q, lin_r;
  logic             in_flat, in_lin;

  always_comb begin
    lin     = ptr_i - PTR_W'(LIN_BASE);
    lin_q   = lin / PTR_W'(GPR_N);
    lin_r   = lin % PTR_W'(GPR_N);
    in_flat = ptr_i < PTR_W'(FLAT_SPAN);
    in_lin  = (ptr_i >= PTR_W'(LIN_BASE)) && (lin < PTR_W'(LIN_SPAN));
    hit_o   = 1'b1;
    bank_o  = bank_sel_i;
    off_o   = off_i;
    if (ind_i) begin
      if (in_flat) begin
        bank_o = ptr_i[OFF_W +: BANK_W];
        off_o  = ptr_i[OFF_W-1:0];
      end else if (in_lin) begin
        bank_o = lin_q[BANK_W-1:0];
        off_o  = lin_r[OFF_W-1:0] + OFF_W'(GPR_LO);
      end else begin
        hit_o  = 1'b0;
        bank_o = '0;
        off_o  = '0;
      end
    end
  end
endmodule

// File: rtl/region_map.sv
// Classifies an in-bank offset and forms the physical index.
module region_map
  import bank_map_pkg::*;
#(
  parameter int GPR_N  = 80,
  parameter int BANK_W = 5,
  parameter int IDX_W  = 12
) (
  input  logic              hit_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  off_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] bank_x, off_x;

  always_comb begin
    bank_x = IDX_W'(bank_i);
    off_x  = IDX_W'(off_i);
    if (!hit_i) begin
      region_o = RG_NONE;
      idx_o    = '0;
    end else if (off_i < OFF_W'(CORE_N)) begin
      region_o = RG_CORE;
      idx_o    = off_x;
    end else if (off_i < OFF_W'(GPR_LO)) begin
      region_o = RG_PERIPH;
      idx_o    = bank_x * IDX_W'(PER_N) + off_x - IDX_W'(CORE_N);
    end else if (off_i < OFF_W'(COM_LO)) begin
      region_o = RG_BANKED;
      idx_o    = bank_x * IDX_W'(GPR_N) + off_x - IDX_W'(GPR_LO);
    end else begin
      region_o = RG_COMMON;
      idx_o    = off_x - IDX_W'(COM_LO);
    end
  end
endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bank_map_pkg::*;
#(
  parameter int NUM_BANKS = 32,
  parameter int GPR_N     = 80,
  parameter int PTR_W     = 16,
  parameter int DATA_W    = 8,
  parameter int LIN_BASE  = 'h2000,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(NUM_BANKS * GPR_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bsel_we_i,
  input  logic [DATA_W-1:0] bsel_wdata_i,
  input  logic              ptr_we_i,
  input  logic [PTR_W-1:0]  ptr_wdata_i,
  input  logic              ind_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              post_inc_i,
  output logic [2:0]        region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [BANK_W-1:0] bank_sel_o,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int LIN_SPAN = NUM_BANKS * GPR_N;

  logic [BANK_W-1:0] bank_sel, src_bank;
  logic [PTR_W-1:0]  ptr;
  logic [OFF_W-1:0]  src_off;
  logic              src_hit;
  region_e           region;

  bank_sel_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bsel (
    .clk_i, .rst_ni, .we_i(bsel_we_i), .wdata_i(bsel_wdata_i), .bank_o(bank_sel));

  ind_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .we_i(ptr_we_i), .wdata_i(ptr_wdata_i),
    .ind_i, .inc_i(post_inc_i), .ptr_o(ptr));

  addr_src #(.NUM_BANKS(NUM_BANKS), .GPR_N(GPR_N), .PTR_W(PTR_W),
             .LIN_BASE(LIN_BASE), .BANK_W(BANK_W)) u_src (
    .ind_i, .bank_sel_i(bank_sel), .off_i, .ptr_i(ptr),
    .hit_o(src_hit), .bank_o(src_bank), .off_o(src_off));

  region_map #(.GPR_N(GPR_N), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_map (
    .hit_i(src_hit), .bank_i(src_bank), .off_i(src_off),
    .region_o(region), .idx_o(idx_o));

  assign region_o   = region;
  assign bank_o     = src_bank;
  assign bank_sel_o = bank_sel;
  assign ptr_o      = ptr;

  AST_CORE_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_i && off_i < OFF_W'(CORE_N)) |-> (region == RG_CORE && idx_o == IDX_W'(off_i))); // R3
  AST_COMMON_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_i && off_i >= OFF_W'(COM_LO)) |-> (region == RG_COMMON && idx_o == IDX_W'(off_i - OFF_W'(COM_LO)))); // R6
  AST_BANKED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region == RG_BANKED |-> idx_o < IDX_W'(LIN_SPAN)); // R5
  AST_LIN_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_i && ptr >= PTR_W'(LIN_BASE) && ptr < PTR_W'(LIN_BASE + LIN_SPAN))
      |-> (region == RG_BANKED && PTR_W'(idx_o) == ptr - PTR_W'(LIN_BASE))); // R8
  AST_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region == RG_NONE |-> (idx_o == '0 && src_bank == '0)); // R10
endmodule

// File: tb/sim_bank_addr_map.sv
module sim_bank_addr_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bwe = 1'b0, pwe = 1'b0, ind = 1'b0, inc = 1'b0;
  logic [7:0]  bw = '0;
  logic [15:0] pw = '0;
  logic [6:0]  off = '0;
  logic [2:0]  region;
  logic [11:0] idx;
  logic [4:0]  bank, bank_sel;
  logic [15:0] ptr;

  always #10 clk = ~clk;

  bank_addr_map u0 (
    .clk_i(clk), .rst_ni(rst_n), .bsel_we_i(bwe), .bsel_wdata_i(bw),
    .ptr_we_i(pwe), .ptr_wdata_i(pw), .ind_i(ind), .off_i(off),
    .post_inc_i(inc), .region_o(region), .idx_o(idx), .bank_o(bank),
    .bank_sel_o(bank_sel), .ptr_o(ptr));

  typedef struct {
    int req, rg, ix, bk, bs, p;
  } item_t;

  item_t q[$];
  int errs = 0, checks = 0;
  int m_bank = 0, m_ptr = 0;

  function automatic void model(input bit i, input int o_in, output int rg, output int ix, output int bk);
    int b, o;
    bit ok = 1;
    if (!i) begin b = m_bank; o = o_in; end
    else if (m_ptr < 4096) begin b = m_ptr / 128; o = m_ptr % 128; end
    else if (m_ptr >= 8192 && m_ptr < 8192 + 32 * 80) begin
      b = (m_ptr - 8192) / 80; o = 32 + (m_ptr - 8192) % 80;
    end else begin ok = 0; b = 0; o = 0; end
    if (!ok) begin rg = 4; ix = 0; bk = 0; end
    else begin
      bk = b;
      if (o < 12)       begin rg = 0; ix = o; end
      else if (o < 32)  begin rg = 1; ix = b * 20 + o - 12; end
      else if (o < 112) begin rg = 2; ix = b * 80 + o - 32; end
      else              begin rg = 3; ix = o - 112; end
    end
  endfunction

  // driver: one cycle of stimulus, expectation from the bench model
  task automatic step(input int req, input bit b_we, input int b_wd, input bit p_we,
                      input int p_wd, input bit i, input int o, input bit pi);
    item_t it;
    @(negedge clk);
    bwe = b_we; bw = 8'(b_wd); pwe = p_we; pw = 16'(p_wd);
    ind = i; off = 7'(o); inc = pi;
    it.req = req; it.bs = m_bank; it.p = m_ptr;
    model(i, o, it.rg, it.ix, it.bk);
    q.push_back(it);
    if (b_we) m_bank = b_wd % 32;
    if (p_we) m_ptr = p_wd;
    else if (i && pi) m_ptr = (m_ptr + 1) % 65536;
  endtask

  task automatic cmp(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares one item per cycle, mid-low-phase
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.req, "region", int'(region), it.rg);
        cmp(it.req, "idx", int'(idx), it.ix);
        cmp(it.req, "bank", int'(bank), it.bk);
        cmp(it.req, "bank_sel", int'(bank_sel), it.bs);
        cmp(it.req, "ptr", int'(ptr), it.p);
      end
    end
  end

  initial begin
    #4_000_000;
    errs++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, 0, 0, 0, 'h00, 0);        // R1 reset state, R3 core
    step(2, 1, 'hE3, 0, 0, 0, 'h09, 0);     // R2 write with upper bits set
    step(3, 0, 0, 0, 0, 0, 'h09, 0);        // R3 working register, bank 3
    step(4, 0, 0, 0, 0, 0, 'h0C, 0);        // R4
    step(4, 0, 0, 0, 0, 0, 'h1F, 0);        // R4
    step(5, 0, 0, 0, 0, 0, 'h20, 0);        // R5
    step(5, 0, 0, 0, 0, 0, 'h6F, 0);        // R5
    step(6, 0, 0, 0, 0, 0, 'h70, 0);        // R6
    step(6, 0, 0, 0, 0, 0, 'h7F, 0);        // R6
    step(1, 1, 'h1F, 0, 0, 0, 'h7F, 0);     // R1 write bank 31
    step(6, 0, 0, 0, 0, 0, 'h7F, 0);        // R6 same in bank 31
    step(5, 0, 0, 0, 0, 0, 'h6F, 0);        // R5 top of banked RAM
    step(3, 0, 0, 0, 0, 0, 'h0B, 0);        // R3
    step(9, 0, 0, 1, 'h0F85, 0, 0, 1);      // R9 load; inc ignored when direct
    step(7, 0, 0, 0, 0, 1, 0, 0);           // R7 flat view bank 31 core
    step(7, 0, 0, 1, 'h0025, 1, 0, 0);
    step(7, 0, 0, 1, 'h1000, 1, 0, 0);      // R7 flat view bank 0 RAM
    step(10, 0, 0, 1, 'h204E, 1, 0, 0);     // R10 unmapped gap
    step(8, 0, 0, 0, 0, 1, 0, 1);           // R8 linear, then post-inc
    step(8, 0, 0, 0, 0, 1, 0, 1);
    step(8, 0, 0, 0, 0, 1, 0, 0);           // R8 crossed into bank 1
    step(8, 1, 1, 0, 0, 0, 'h20, 0);        // R8 direct twin of linear 0x2050
    step(8, 0, 0, 1, 'h29FF, 0, 'h20, 0);
    step(8, 0, 0, 0, 0, 1, 0, 1);           // R8 last linear byte
    step(10, 0, 0, 0, 0, 1, 0, 0);          // R10 just past the window
    step(9, 0, 0, 1, 'hFFFF, 1, 0, 1);      // R9 load beats increment
    step(9, 0, 0, 0, 0, 1, 0, 1);           // R9 wrap
    step(9, 0, 0, 0, 0, 1, 0, 0);
    step(9, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    bwe = 0; pwe = 0; inc = 0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule